// File: doc/BRIEF.md
# Extracode-Aware Instruction Address Decoder

This block takes one 48-bit instruction word and turns it into what the next stage needs. It splits the word into a function code, two index selectors and a 24-bit address. It adds the two selected 24-bit index values to the address, with the sum wrapping modulo 2^24. It then decides whether the instruction is executed directly or handed to a fixed-store interpretive routine. For a routine, it gives the entry point and passes on the modified address as the routine's parameter.

The top bit of the effective address marks the private region. An access there is refused unless the instruction itself was fetched from the fixed store. A refused access is reported as a protection fault and withholds the effective address. The block holds the 128-entry index register file, which has one write port. Instructions enter through a valid/ready handshake, and the decoded result sits in an output register until the consumer takes it.

Top module: `instr_addr_decoder`

## Requirements
- R1: After reset, `out_valid_o` is 0 and `in_ready_o` is 1; `in_ready_o` is 1 whenever no result is pending.
- R2: The effective address is (instr[23:0] + X[instr[37:31]] + X[instr[30:24]]) mod 2^24, where X is the index register file.
- R3: Selector value 0 always reads as zero, and a write to entry 0 has no effect.
- R4: If instr[47] is 1, the dispatch is extracode (code 1) and `entry_o` = instr[46:38]. If instr[47] is 0, the dispatch is basic (code 0) and `entry_o` = instr[46:38] as the opcode. In both cases `ea_valid_o` is 1.
- R5: `char_pos_o` is effective address bits [2:0] and `ea_word_o` is bits [23:3].
- R6: If effective address bit 23 is 1 and `fixed_fetch_i` is 0, the result is a protection fault: dispatch code 2, `prot_fault_o` = 1, `ea_valid_o` = 0 and `entry_o` = 0. This overrides extracode dispatch.
- R7: If `fixed_fetch_i` is 1, a private-region address decodes normally, with no fault.
- R8: A result appears on the outputs at the first clock edge after an accepted instruction. It stays unchanged while `out_valid_o` is 1 and `out_ready_i` is 0.
- R9: An index write takes effect at its clock edge. An instruction accepted at that same edge uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idx_we_i | input | 1 | Index register write enable |
| idx_waddr_i | input | 7 | Index register write select |
| idx_wdata_i | input | 24 | Index register write value |
| in_valid_i | input | 1 | Instruction present |
| in_ready_o | output | 1 | Decoder can take an instruction |
| instr_i | input | 48 | Instruction word |
| fixed_fetch_i | input | 1 | Instruction was fetched from the fixed store |
| out_valid_o | output | 1 | Decoded result present |
| out_ready_i | input | 1 | Consumer takes the result |
| dispatch_o | output | 2 | 0 basic, 1 extracode, 2 protection fault |
| entry_o | output | 9 | Routine entry point or basic opcode |
| ea_valid_o | output | 1 | Effective address usable |
| ea_word_o | output | 21 | Effective word address |
| char_pos_o | output | 3 | Character position in the word |
| prot_fault_o | output | 1 | Private-region access refused |

## Verification
Every decoded field is due exactly one clock after the edge that accepts the instruction. It stays due for as long as the consumer holds `out_ready_i` low. `in_ready_o` is combinational and is due in the same cycle as the inputs that set it. The bench drives inputs just after a falling edge and checks `in_ready_o` one nanosecond later. It then predicts the register contents for the coming rising edge, using index values from before any write at that edge. It compares every output at the next falling edge. Each comparison therefore sits half a period away from the edge that produced the value.

// File: rtl/iad_pkg.sv
package iad_pkg;
  localparam int unsigned WORD_W = 48;
  localparam int unsigned FUNC_W = 10;
  localparam int unsigned SEL_W  = 7;
  localparam int unsigned ADDR_W = 24;
  localparam int unsigned CHAR_W = 3;
  localparam int unsigned CODE_W = FUNC_W - 1;

  typedef enum logic [1:0] {
    DISP_BASIC = 2'd0,
    DISP_EXTRA = 2'd1,
    DISP_FAULT = 2'd2
  } disp_e;
endpackage

// File: rtl/iad_field_split.sv
module iad_field_split #(
  parameter int unsigned FUNC_W = iad_pkg::FUNC_W,
  parameter int unsigned SEL_W  = iad_pkg::SEL_W,
  parameter int unsigned ADDR_W = iad_pkg::ADDR_W,
  localparam int unsigned WORD_W = FUNC_W + 2 * SEL_W + ADDR_W,
  localparam int unsigned CODE_W = FUNC_W - 1
) (
  input  logic [WORD_W-1:0] instr_i,
  output logic              ext_o,
  output logic [CODE_W-1:0] code_o,
  output logic [SEL_W-1:0]  sel_a_o,
  output logic [SEL_W-1:0]  sel_b_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned SB_LO = ADDR_W;
  localparam int unsigned SA_LO = ADDR_W + SEL_W;
  localparam int unsigned FN_LO = ADDR_W + 2 * SEL_W;

  assign ext_o   = instr_i[WORD_W-1];
  assign code_o  = instr_i[FN_LO +: CODE_W];
  assign sel_a_o = instr_i[SA_LO +: SEL_W];
  assign sel_b_o = instr_i[SB_LO +: SEL_W];
  assign addr_o  = instr_i[ADDR_W-1:0];
endmodule

// File: rtl/iad_index_file.sv
module iad_index_file #(
  parameter int unsigned SEL_W  = iad_pkg::SEL_W,
  parameter int unsigned DATA_W = iad_pkg::ADDR_W,
  parameter int unsigned NRD    = 2,
  localparam int unsigned NUM   = 1 << SEL_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [SEL_W-1:0]           waddr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic [NRD-1:0][SEL_W-1:0]  rsel_i,
  output logic [NRD-1:0][DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] regs_q [NUM];

  // entry 0 is never written and stays zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM; i++) regs_q[i] <= '0;
    end else if (we_i && (waddr_i != '0)) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata_o[p] = (rsel_i[p] == '0) ? '0 : regs_q[rsel_i[p]];
  end
endmodule

// File: rtl/iad_addr_gen.sv
module iad_addr_gen #(
  parameter int unsigned ADDR_W = iad_pkg::ADDR_W,
  parameter int unsigned CHAR_W = iad_pkg::CHAR_W,
  parameter int unsigned NIDX   = 2,
  localparam int unsigned WADR_W = ADDR_W - CHAR_W
) (
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [NIDX-1:0][ADDR_W-1:0] idx_i,
  output logic [WADR_W-1:0]           word_o,
  output logic [CHAR_W-1:0]           char_o,
  output logic                        priv_o
);
  logic [NIDX:0][ADDR_W-1:0] sum;

  assign sum[0] = addr_i;
  for (genvar k = 0; k < NIDX; k++) begin : g_add
    assign sum[k+1] = sum[k] + idx_i[k];  // wraps at 2^ADDR_W
  end

  assign word_o = sum[NIDX][ADDR_W-1:CHAR_W];
  assign char_o = sum[NIDX][CHAR_W-1:0];
  assign priv_o = sum[NIDX][ADDR_W-1];
endmodule

// File: rtl/iad_dispatch.sv
module iad_dispatch #(
  parameter int unsigned CODE_W = iad_pkg::CODE_W
) (
  input  logic                ext_i,
  input  logic [CODE_W-1:0]   code_i,
  input  logic                priv_i,
  input  logic                fixed_fetch_i,
  output iad_pkg::disp_e      disp_o,
  output logic [CODE_W-1:0]   entry_o,
  output logic                ea_valid_o,
  output logic                fault_o
);
  import iad_pkg::*;

  always_comb begin
    fault_o    = priv_i && !fixed_fetch_i;
    ea_valid_o = !fault_o;
    entry_o    = fault_o ? '0 : code_i;
    if (fault_o)    disp_o = DISP_FAULT;
    else if (ext_i) disp_o = DISP_EXTRA;
    else            disp_o = DISP_BASIC;
  end
endmodule

// File: rtl/instr_addr_decoder.sv
module instr_addr_decoder #(
  parameter int unsigned FUNC_W = iad_pkg::FUNC_W,
  parameter int unsigned SEL_W  = iad_pkg::SEL_W,
  parameter int unsigned ADDR_W = iad_pkg::ADDR_W,
  parameter int unsigned CHAR_W = iad_pkg::CHAR_W,
  localparam int unsigned WORD_W = FUNC_W + 2 * SEL_W + ADDR_W,
  localparam int unsigned CODE_W = FUNC_W - 1,
  localparam int unsigned WADR_W = ADDR_W - CHAR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idx_we_i,
  input  logic [SEL_W-1:0]  idx_waddr_i,
  input  logic [ADDR_W-1:0] idx_wdata_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [WORD_W-1:0] instr_i,
  input  logic              fixed_fetch_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [1:0]        dispatch_o,
  output logic [CODE_W-1:0] entry_o,
  output logic              ea_valid_o,
  output logic [WADR_W-1:0] ea_word_o,
  output logic [CHAR_W-1:0] char_pos_o,
  output logic              prot_fault_o
);
  import iad_pkg::*;

  logic              ext;
  logic [CODE_W-1:0] code;
  logic [SEL_W-1:0]  sel_a, sel_b;
  logic [ADDR_W-1:0] addr;
  logic [1:0][SEL_W-1:0]  rsel;
  logic [1:0][ADDR_W-1:0] rdata;
  logic [WADR_W-1:0] word_d;
  logic [CHAR_W-1:0] char_d;
  logic              priv_d;
  disp_e             disp_d;
  logic [CODE_W-1:0] entry_d;
  logic              eav_d, fault_d;
  logic              accept;

  iad_field_split #(.FUNC_W(FUNC_W), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_split (
    .instr_i (instr_i),
    .ext_o   (ext),
    .code_o  (code),
    .sel_a_o (sel_a),
    .sel_b_o (sel_b),
    .addr_o  (addr)
  );

  assign rsel[0] = sel_a;
  assign rsel[1] = sel_b;

  iad_index_file #(.SEL_W(SEL_W), .DATA_W(ADDR_W), .NRD(2)) u_idx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (idx_we_i),
    .waddr_i (idx_waddr_i),
    .wdata_i (idx_wdata_i),
    .rsel_i  (rsel),
    .rdata_o (rdata)
  );

  iad_addr_gen #(.ADDR_W(ADDR_W), .CHAR_W(CHAR_W), .NIDX(2)) u_agen (
    .addr_i (addr),
    .idx_i  (rdata),
    .word_o (word_d),
    .char_o (char_d),
    .priv_o (priv_d)
  );

  iad_dispatch #(.CODE_W(CODE_W)) u_disp (
    .ext_i         (ext),
    .code_i        (code),
    .priv_i        (priv_d),
    .fixed_fetch_i (fixed_fetch_i),
    .disp_o        (disp_d),
    .entry_o       (entry_d),
    .ea_valid_o    (eav_d),
    .fault_o       (fault_d)
  );

  assign in_ready_o = !out_valid_o || out_ready_i;
  assign accept     = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o  <= 1'b0;
      dispatch_o   <= DISP_BASIC;
      entry_o      <= '0;
      ea_valid_o   <= 1'b0;
      ea_word_o    <= '0;
      char_pos_o   <= '0;
      prot_fault_o <= 1'b0;
    end else if (accept) begin
      out_valid_o  <= 1'b1;
      dispatch_o   <= disp_d;
      entry_o      <= entry_d;
      ea_valid_o   <= eav_d;
      ea_word_o    <= word_d;
      char_pos_o   <= char_d;
      prot_fault_o <= fault_d;
    end else if (out_ready_i) begin
      out_valid_o  <= 1'b0;
    end
  end

  assert_ready_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> in_ready_o);

  assert_fault_no_ea_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && prot_fault_o |-> !ea_valid_o && dispatch_o == DISP_FAULT);

  assert_fault_private_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && prot_fault_o |-> ea_word_o[WADR_W-1]);

  assert_extra_clean_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && dispatch_o == DISP_EXTRA |-> ea_valid_o && !prot_fault_o);

  assert_latency_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o);

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(dispatch_o) &&
    $stable(entry_o) && $stable(ea_word_o) && $stable(char_pos_o) &&
    $stable(ea_valid_o) && $stable(prot_fault_o));
endmodule

// File: tb/tb_instr_addr_decoder.sv
`timescale 1ns/1ps
module tb_instr_addr_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        idx_we = 1'b0;
  logic [6:0]  idx_waddr = '0;
  logic [23:0] idx_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [47:0] instr = '0;
  logic        fixed_fetch = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [1:0]  dispatch;
  logic [8:0]  entry;
  logic        ea_valid;
  logic [20:0] ea_word;
  logic [2:0]  char_pos;
  logic        prot_fault;

  int checks = 0;
  int fails  = 0;

  // reference model state
  logic [23:0] xr [128];
  logic        m_valid = 1'b0;
  logic [1:0]  m_disp;
  logic [8:0]  m_entry;
  logic        m_eav;
  logic [20:0] m_word;
  logic [2:0]  m_char;
  logic        m_fault;

  always #2.5 clk = ~clk;

  instr_addr_decoder dut (
    .clk_i(clk), .rst_ni(rst_n),
    .idx_we_i(idx_we), .idx_waddr_i(idx_waddr), .idx_wdata_i(idx_wdata),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .instr_i(instr),
    .fixed_fetch_i(fixed_fetch),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .dispatch_o(dispatch), .entry_o(entry), .ea_valid_o(ea_valid),
    .ea_word_o(ea_word), .char_pos_o(char_pos), .prot_fault_o(prot_fault)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [47:0] mk(input logic ext, input logic [8:0] code,
      input logic [6:0] a, input logic [6:0] b, input logic [23:0] ad);
    return {ext, code, a, b, ad};
  endfunction

  task automatic compare(input string req);
    chk(req, "out_valid R8", 32'(out_valid), 32'(m_valid));
    if (m_valid) begin
      chk(req, "dispatch R4/R6", 32'(dispatch), 32'(m_disp));
      chk(req, "entry R4", 32'(entry), 32'(m_entry));
      chk(req, "ea_valid R6", 32'(ea_valid), 32'(m_eav));
      chk(req, "ea_word R2/R5", 32'(ea_word), 32'(m_word));
      chk(req, "char_pos R5", 32'(char_pos), 32'(m_char));
      chk(req, "prot_fault R6/R7", 32'(prot_fault), 32'(m_fault));
    end
  endtask

  // one clock: drive, predict, wait for the falling edge, compare
  task automatic step(input string req, input logic iv, input logic [47:0] ins,
      input logic ff, input logic ordy, input logic we,
      input logic [6:0] wa, input logic [23:0] wd);
    logic acc;
    logic [23:0] ea;
    logic pf;
    in_valid = iv; instr = ins; fixed_fetch = ff; out_ready = ordy;
    idx_we = we; idx_waddr = wa; idx_wdata = wd;
    #1;
    chk(req, "in_ready R1", 32'(in_ready), 32'(!m_valid || ordy));
    acc = iv && (!m_valid || ordy);
    if (acc) begin
      ea = ins[23:0] + (ins[37:31] == 0 ? 24'd0 : xr[ins[37:31]])
                     + (ins[30:24] == 0 ? 24'd0 : xr[ins[30:24]]);
      pf = ea[23] && !ff;
      m_valid = 1'b1;
      m_fault = pf;
      m_eav   = !pf;
      m_disp  = pf ? 2'd2 : (ins[47] ? 2'd1 : 2'd0);
      m_entry = pf ? 9'd0 : ins[46:38];
      m_word  = ea[23:3];
      m_char  = ea[2:0];
    end else if (ordy) begin
      m_valid = 1'b0;
    end
    if (we && wa != 0) xr[wa] = wd;
    @(negedge clk);
    compare(req);
  endtask

  task automatic wr(input logic [6:0] a, input logic [23:0] d);
    step("R3", 1'b0, '0, 1'b0, 1'b1, 1'b1, a, d);
  endtask

  task automatic go(input string req, input logic [47:0] ins, input logic ff);
    step(req, 1'b1, ins, ff, 1'b1, 1'b0, '0, '0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    for (int i = 0; i < 128; i++) xr[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "out_valid", 32'(out_valid), 32'd0);
    chk("R1", "in_ready", 32'(in_ready), 32'd1);

    // index loads
    wr(7'd1, 24'h000010);
    wr(7'd2, 24'h000203);
    wr(7'd3, 24'hFFFFFF);
    wr(7'd4, 24'h400000);
    wr(7'd127, 24'h123456);

    go("R2", mk(1'b0, 9'h055, 7'd0, 7'd0, 24'h001000), 1'b0);
    go("R2", mk(1'b0, 9'h0AA, 7'd1, 7'd0, 24'h001000), 1'b0);
    go("R2", mk(1'b0, 9'h101, 7'd1, 7'd2, 24'h001000), 1'b0);
    go("R2", mk(1'b0, 9'h002, 7'd127, 7'd127, 24'h000001), 1'b0);
    go("R2", mk(1'b0, 9'h003, 7'd3, 7'd3, 24'h000005), 1'b0);  // wrap mod 2^24

    // write to entry 0 ignored
    wr(7'd0, 24'h0ABCDE);
    go("R3", mk(1'b0, 9'h004, 7'd0, 7'd0, 24'h000100), 1'b0);

    go("R4", mk(1'b1, 9'h1FF, 7'd0, 7'd0, 24'h000777), 1'b0);
    go("R4", mk(1'b1, 9'h000, 7'd2, 7'd1, 24'h000008), 1'b0);

    for (int c = 0; c < 8; c++)
      go("R5", mk(1'b0, 9'h010, 7'd0, 7'd0, 24'h002340 + 24'(c)), 1'b0);

    go("R6", mk(1'b0, 9'h020, 7'd0, 7'd0, 24'h800000), 1'b0);
    go("R6", mk(1'b1, 9'h1AB, 7'd4, 7'd4, 24'h000003), 1'b0);   // 0x800003 via index
    go("R6", mk(1'b0, 9'h021, 7'd4, 7'd0, 24'h000000), 1'b0);
    go("R7", mk(1'b1, 9'h1AB, 7'd4, 7'd4, 24'h000003), 1'b1);
    go("R7", mk(1'b0, 9'h022, 7'd0, 7'd0, 24'hFFFFF9), 1'b1);

    // back-pressure
    step("R8", 1'b1, mk(1'b0, 9'h033, 7'd1, 7'd0, 24'h000040), 1'b0, 1'b0, 1'b0, '0, '0);
    for (int s = 0; s < 4; s++)
      step("R8", 1'b1, mk(1'b1, 9'h044, 7'd0, 7'd0, 24'h000050), 1'b0, 1'b0, 1'b0, '0, '0);
    step("R8", 1'b0, '0, 1'b0, 1'b1, 1'b0, '0, '0);
    step("R8", 1'b0, '0, 1'b0, 1'b1, 1'b0, '0, '0);

    // same-edge write and use
    step("R9", 1'b1, mk(1'b0, 9'h055, 7'd5, 7'd0, 24'h000100), 1'b0, 1'b1, 1'b1, 7'd5, 24'h000700);
    go("R9", mk(1'b0, 9'h056, 7'd5, 7'd0, 24'h000100), 1'b0);

    for (int n = 0; n < 400; n++) begin
      logic [47:0] ri;
      ri = {$urandom, $urandom};
      step("R2", ($urandom % 4) != 0, ri, ($urandom % 3) == 0, ($urandom % 4) != 0,
           ($urandom % 5) == 0, 7'($urandom), 24'($urandom));
    end
    step("R8", 1'b0, '0, 1'b0, 1'b1, 1'b0, '0, '0);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule